// File: doc/BRIEF.md
# Key Cache with Address Search

This block holds a table of cipher key entries for a wireless MAC. Software fills and inspects the table through a 32-bit word bus. Each entry spans eight bus words: five key words, a type word and two address words. Behind the bus the storage is 64 bits wide. An even-numbered word is therefore only parked in a staging register, and the following odd word of the same pair writes both halves in one step.

The receive path asks for a key by presenting a 48-bit station address and a group flag on the search port. One cycle later it gets back a hit flag, the lowest matching index, the cipher type and the 128-bit key. Addresses sit in the table shifted right by one bit. The freed bit becomes a unicast flag, so one address can hold separate unicast and group entries. When integrity-key support is on, a TKIP entry also returns its receive integrity key, which lives in the slot `MIC_OFS` entries above it.

Top module: `key_cache_search`

## Requirements
- R1: A write to an even word (bus address bit 0 = 0) changes no stored word. The next write to the odd word of the same pair (word index 2p, 2p+1) stores both halves at once, and both read back afterwards.
- R2: An odd-word write is ignored unless the most recent staged even word belongs to the same pair of the same entry.
- R3: Bus address = entry*8 + word. Words 0,2,4 are key words (32 bits); words 1 and 3 are key words whose upper 16 bits read as zero. Word 5 is the type word: bits 2:0 hold the cipher code (0 clear, 1 WEP-40, 2 WEP-104, 3 WEP-128, 4 TKIP, 5 AES-OCB, 6 AES-CCM), bit 8 is the power-management bit, and all other bits read zero. Word 6 holds address bits 32:1. Word 7 holds address bits 47:33 in bits 14:0 and the unicast flag in bit 15, with higher bits zero.
- R4: Bus writes to the type word leave its power-management bit unchanged. Only the `pm_we` port changes that bit.
- R5: Reads return data one cycle after `bus_re`. A write to an entry index at or above `DEPTH` is ignored, and a read from such an index returns zero.
- R6: The search result appears one cycle after `srch_req`. An entry matches when its stored 47 address bits equal `srch_addr[47:1]` and its unicast flag is 1 for `srch_group`=0, or 0 for `srch_group`=1.
- R7: On a miss the result has hit 0, index 0, type clear (0), key 0 and no integrity key.
- R8: When several entries match, the lowest index is returned.
- R9: An entry whose two address words are both zero never matches.
- R10: The key output is {word4, word3[15:0], word2, word1[15:0], word0}, with word0 in the least significant bits. For WEP-40 and WEP-104 entries only the low 8 bits of word4 are passed on.
- R11: With `mic_en`=1, a TKIP hit at index i sets `srch_mic_vld` and returns {word2, word0} of slot i+`MIC_OFS`. With `mic_en`=1, a TKIP entry at index `DEPTH`-`MIC_OFS` or higher never matches. With `mic_en`=0, TKIP entries match at any index and `srch_mic_vld` stays 0.
- R12: A search issued in the same cycle as a commit to the searched entry returns the complete contents from before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus word write strobe |
| bus_re | input | 1 | Bus word read strobe |
| bus_addr | input | BUS_AW | Word address, entry*8 + word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_re` |
| pm_we | input | 1 | MAC write of a power-management bit |
| pm_idx | input | $clog2(DEPTH) | Entry whose power-management bit is written |
| pm_val | input | 1 | New power-management bit value |
| mic_en | input | 1 | Integrity-key companion slots in use |
| srch_req | input | 1 | Start a search |
| srch_addr | input | 48 | Address to look up |
| srch_group | input | 1 | 1 for a group or broadcast destination |
| srch_vld | output | 1 | Search result valid (one-cycle pulse) |
| srch_hit | output | 1 | An entry matched |
| srch_idx | output | $clog2(DEPTH) | Matching entry index |
| srch_type | output | 3 | Cipher code of the match |
| srch_key | output | 128 | Key of the match |
| srch_mic_vld | output | 1 | Integrity key returned |
| srch_mic | output | 64 | Receive integrity key {word2, word0} of the companion slot |

## Verification
The hardest case to reach is R12, where a commit to an entry lands in the same cycle as a search for that entry. The bench stages the new low address word of an entry, then drives the odd address-word write and a search for the old address on the same clock edge. It expects a hit with the old contents, and then a miss on the old address and a hit on the new one. The integrity-key rules are the other awkward corner. They need a TKIP entry placed below and above the `DEPTH`-`MIC_OFS` boundary and a companion slot filled, and the bench toggles `mic_en` to show both behaviours.

// File: rtl/key_cache_search.sv
module key_cache_search #(
  parameter int DEPTH   = 128,
  parameter int MIC_OFS = 64,
  parameter int BUS_AW  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic                     bus_re,
  input  logic [BUS_AW-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     pm_we,
  input  logic [$clog2(DEPTH)-1:0] pm_idx,
  input  logic                     pm_val,
  input  logic                     mic_en,
  input  logic                     srch_req,
  input  logic [47:0]              srch_addr,
  input  logic                     srch_group,
  output logic                     srch_vld,
  output logic                     srch_hit,
  output logic [$clog2(DEPTH)-1:0] srch_idx,
  output logic [2:0]               srch_type,
  output logic [127:0]             srch_key,
  output logic                     srch_mic_vld,
  output logic [63:0]              srch_mic
);
  localparam int DW = $clog2(DEPTH);
  localparam int IW = BUS_AW - 3;
  localparam int NP = DEPTH * 4;
  localparam logic [2:0] TY_TKIP = 3'd4;

  logic [63:0] pr [NP];

  wire [IW-1:0]  b_ent  = bus_addr[BUS_AW-1:3];
  wire [2:0]     b_wrd  = bus_addr[2:0];
  wire           b_ok   = 32'(b_ent) < DEPTH;
  wire [DW+1:0]  b_pair = {b_ent[DW-1:0], b_wrd[2:1]};

  logic          stg_v;
  logic [DW+1:0] stg_p;
  logic [31:0]   stg_d;

  wire stg_hit = stg_v && stg_p == b_pair;
  wire commit  = bus_we && b_ok && b_wrd[0] && stg_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) pr[i] <= '0;
      stg_v <= 1'b0;
      stg_p <= '0;
      stg_d <= '0;
    end else begin
      if (bus_we && b_ok && !b_wrd[0]) begin
        stg_v <= 1'b1;
        stg_p <= b_pair;
        stg_d <= bus_wdata;
      end else if (commit) begin
        stg_v <= 1'b0;
      end
      if (commit) begin
        if (b_wrd[2:1] == 2'd2)
          pr[b_pair] <= {23'b0, pr[b_pair][40], 5'b0, bus_wdata[2:0], stg_d};
        else
          pr[b_pair] <= {bus_wdata, stg_d};
      end
      if (pm_we) pr[{pm_idx, 2'd2}][40] <= pm_val;
    end
  end

  logic [31:0] rd_word, rd_mask;
  assign rd_word = b_wrd[0] ? pr[b_pair][63:32] : pr[b_pair][31:0];
  always_comb begin
    case (b_wrd)
      3'd1, 3'd3, 3'd7: rd_mask = 32'h0000_FFFF;
      3'd5:             rd_mask = 32'h0000_0107;
      default:          rd_mask = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= b_ok ? (rd_word & rd_mask) : 32'h0;
  end

  logic [DEPTH-1:0] ent_match;
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam bit NO_MIC_ROOM = (g + MIC_OFS) >= DEPTH;
    wire [46:0] sa  = {pr[4*g+3][46:32], pr[4*g+3][31:0]};
    wire [2:0]  ty  = pr[4*g+2][34:32];
    wire        bad = mic_en && ty == TY_TKIP && NO_MIC_ROOM;
    assign ent_match[g] = sa != '0 && sa == srch_addr[47:1] &&
                          pr[4*g+3][47] == !srch_group && !bad;
  end

  logic          m_hit;
  logic [DW-1:0] m_idx;
  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (ent_match[i]) begin
        m_hit = 1'b1;
        m_idx = DW'(i);
      end
  end

  wire [63:0]   h0  = pr[{m_idx, 2'd0}];
  wire [63:0]   h1  = pr[{m_idx, 2'd1}];
  wire [63:0]   h2  = pr[{m_idx, 2'd2}];
  wire [2:0]    hty = h2[34:32];
  wire [31:0]   hk4 = (hty == 3'd1 || hty == 3'd2) ? {24'b0, h2[7:0]} : h2[31:0];
  wire [DW-1:0] mi  = DW'(32'(m_idx) + MIC_OFS);
  wire          mok = mic_en && hty == TY_TKIP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srch_vld     <= 1'b0;
      srch_hit     <= 1'b0;
      srch_idx     <= '0;
      srch_type    <= '0;
      srch_key     <= '0;
      srch_mic_vld <= 1'b0;
      srch_mic     <= '0;
    end else begin
      srch_vld <= srch_req;
      if (srch_req) begin
        srch_hit     <= m_hit;
        srch_idx     <= m_hit ? m_idx : '0;
        srch_type    <= m_hit ? hty : 3'd0;
        srch_key     <= m_hit ? {hk4, h1[47:32], h1[31:0], h0[47:32], h0[31:0]} : '0;
        srch_mic_vld <= m_hit && mok;
        srch_mic     <= (m_hit && mok) ? {pr[{mi, 2'd1}][31:0], pr[{mi, 2'd0}][31:0]} : '0;
      end
    end
  end

  assert_odd_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && b_ok && b_wrd[0] && !stg_hit && !pm_we) |=> pr[$past(b_pair)] == $past(pr[b_pair]));

  assert_pm_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && b_wrd[2:1] == 2'd2 && !pm_we) |=> pr[$past(b_pair)][40] == $past(pr[b_pair][40]));

  assert_oor_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !b_ok) |=> bus_rdata == 32'h0);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    srch_req |=> srch_vld);

  assert_miss_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_vld && !srch_hit) |-> (srch_type == 3'd0 && srch_key == '0 && !srch_mic_vld));

  assert_mic_tkip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srch_mic_vld |-> (srch_hit && srch_type == TY_TKIP &&
                      32'(srch_idx) + MIC_OFS < DEPTH));
endmodule

// File: tb/key_cache_search_test.sv
module key_cache_search_test;
  localparam int DEPTH = 128, MIC_OFS = 64, BUS_AW = 12, DW = 7;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_re = 0;
  logic [BUS_AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic pm_we = 0, pm_val = 0, mic_en = 0;
  logic [DW-1:0] pm_idx = '0;
  logic srch_req = 0, srch_group = 0;
  logic [47:0] srch_addr = '0;
  logic srch_vld, srch_hit, srch_mic_vld;
  logic [DW-1:0] srch_idx;
  logic [2:0] srch_type;
  logic [127:0] srch_key;
  logic [63:0] srch_mic;

  int nchk = 0, nfail = 0;

  key_cache_search #(.DEPTH(DEPTH), .MIC_OFS(MIC_OFS), .BUS_AW(BUS_AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pm_we(pm_we), .pm_idx(pm_idx),
    .pm_val(pm_val), .mic_en(mic_en), .srch_req(srch_req), .srch_addr(srch_addr),
    .srch_group(srch_group), .srch_vld(srch_vld), .srch_hit(srch_hit),
    .srch_idx(srch_idx), .srch_type(srch_type), .srch_key(srch_key),
    .srch_mic_vld(srch_mic_vld), .srch_mic(srch_mic));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] got, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int e, input int w, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = BUS_AW'(e * 8 + w); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_chk(input int e, input int w, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_re = 1; bus_addr = BUS_AW'(e * 8 + w);
    @(negedge clk);
    bus_re = 0;
    chk(bus_rdata == exp, req, 128'(bus_rdata), 128'(exp));
  endtask

  task automatic srch(input logic [47:0] a, input logic grp);
    @(negedge clk);
    srch_req = 1; srch_addr = a; srch_group = grp;
    @(negedge clk);
    srch_req = 0;
  endtask

  task automatic set_ent(input int e, input logic [47:0] a, input logic uni,
                         input logic [2:0] ty, input logic [127:0] k);
    wr(e, 0, k[31:0]);   wr(e, 1, {16'h0, k[47:32]});
    wr(e, 2, k[79:48]);  wr(e, 3, {16'h0, k[95:80]});
    wr(e, 4, k[127:96]); wr(e, 5, {29'h0, ty});
    wr(e, 6, a[32:1]);   wr(e, 7, {16'h0, uni, a[47:33]});
  endtask

  function automatic logic [47:0] uaddr(input int i);
    return {8'h0A, 8'(i), 8'h35, 8'(i) ^ 8'h5A, 8'h11, 7'(i), 1'b0};
  endfunction

  function automatic logic [127:0] mkkey(input int i);
    return {32'hC0DE_0000 + 32'(i), 16'h1000 + 16'(i), 32'hBEEF_0000 + 32'(i),
            16'h2000 + 16'(i), 32'hF00D_0000 + 32'(i)};
  endfunction

  function automatic logic [127:0] expkey(input logic [127:0] k, input logic [2:0] ty);
    return (ty == 3'd1 || ty == 3'd2) ? {24'h0, k[103:0]} : k;
  endfunction

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(srch_vld == 0 && srch_hit == 0, "R7 reset state", {srch_vld, srch_hit}, 0);
    rd_chk(0, 5, 32'h0, "R5 reset read");

    wr(5, 0, 32'hA5A5_0001);
    rd_chk(5, 0, 32'h0, "R1 even only staged");
    wr(5, 1, 32'h1234_BEEF);
    rd_chk(5, 0, 32'hA5A5_0001, "R1 even half committed");
    rd_chk(5, 1, 32'h0000_BEEF, "R1 R3 odd half masked");

    wr(5, 3, 32'h0000_7777);
    rd_chk(5, 3, 32'h0, "R2 lone odd ignored");
    wr(5, 2, 32'h2222_2222);
    wr(5, 5, 32'h0000_0003);
    rd_chk(5, 5, 32'h0, "R2 odd of other pair ignored");
    wr(5, 3, 32'h0000_3333);
    rd_chk(5, 2, 32'h2222_2222, "R1 staged word survives");
    rd_chk(5, 3, 32'h0000_3333, "R1 pair committed");

    @(negedge clk); pm_we = 1; pm_idx = 7'd5; pm_val = 1;
    @(negedge clk); pm_we = 0;
    wr(5, 4, 32'h4444_4444); wr(5, 5, 32'hFFFF_FEF6);
    rd_chk(5, 5, 32'h0000_0106, "R4 R3 type word keeps pm bit");
    wr(5, 4, 32'h4444_4444); wr(5, 5, 32'h0000_0100);
    @(negedge clk); pm_we = 1; pm_val = 0;
    @(negedge clk); pm_we = 0;
    wr(5, 4, 32'h4444_4444); wr(5, 5, 32'h0000_0101);
    rd_chk(5, 5, 32'h0000_0001, "R4 pm bit cleared only by port");
    wr(5, 6, 32'hFFFF_FFFF); wr(5, 7, 32'hFFFF_FFFF);
    rd_chk(5, 7, 32'h0000_FFFF, "R3 address high word mask");

    wr(200, 0, 32'hDEAD_BEEF); wr(200, 1, 32'hDEAD_BEEF);
    rd_chk(200, 0, 32'h0, "R5 out-of-range read zero");
    rd_chk(5, 4, 32'h4444_4444, "R5 in-range read intact");

    for (int i = 0; i < 16; i++) begin
      int t = i % 6;
      logic [2:0] ty;
      ty = 3'(t < 4 ? t : t + 1);
      set_ent(i, uaddr(i), 1'b1, ty, mkkey(i));
    end
    for (int i = 0; i < 16; i++) begin
      int t = i % 6;
      logic [2:0] ty;
      ty = 3'(t < 4 ? t : t + 1);
      srch(uaddr(i), 1'b0);
      chk(srch_vld && srch_hit && srch_idx == 7'(i), "R6 unicast hit index",
          {srch_hit, srch_idx}, {1'b1, 7'(i)});
      chk(srch_type == ty, "R6 type", 128'(srch_type), 128'(ty));
      chk(srch_key == expkey(mkkey(i), ty), "R10 key layout and mask",
          srch_key, expkey(mkkey(i), ty));
      srch(uaddr(i) | 48'h1, 1'b1);
      chk(srch_vld && !srch_hit && srch_type == 0 && srch_key == 0 && srch_idx == 0,
          "R6 R7 group search misses unicast entry", {srch_hit, srch_type}, 0);
    end

    set_ent(20, 48'h0B00_0000_1234, 1'b1, 3'd5, mkkey(20));
    set_ent(30, 48'h0B00_0000_1234, 1'b1, 3'd6, mkkey(30));
    srch(48'h0B00_0000_1234, 1'b0);
    chk(srch_hit && srch_idx == 7'd20, "R8 lowest index wins", 128'(srch_idx), 128'(20));
    wr(20, 6, 32'h0); wr(20, 7, 32'h0);
    srch(48'h0B00_0000_1234, 1'b0);
    chk(srch_hit && srch_idx == 7'd30 && srch_type == 3'd6, "R8 next match", 128'(srch_idx), 128'(30));

    srch(48'h0000_0000_0001, 1'b1);
    chk(!srch_hit, "R9 zero-address entries never match", 128'(srch_hit), 0);

    mic_en = 1;
    set_ent(40, 48'h0D00_0000_4040, 1'b1, 3'd4, mkkey(40));
    wr(104, 0, 32'h1111_2222); wr(104, 1, 32'h0);
    wr(104, 2, 32'h3333_4444); wr(104, 3, 32'h0);
    srch(48'h0D00_0000_4040, 1'b0);
    chk(srch_hit && srch_idx == 7'd40 && srch_mic_vld, "R11 TKIP hit with integrity key",
        {srch_hit, srch_mic_vld}, 2'b11);
    chk(srch_mic == 64'h3333_4444_1111_2222, "R11 integrity key value",
        128'(srch_mic), 128'(64'h3333_4444_1111_2222));
    set_ent(70, 48'h0D00_0000_7070, 1'b1, 3'd4, mkkey(70));
    srch(48'h0D00_0000_7070, 1'b0);
    chk(!srch_hit, "R11 TKIP above boundary unusable", 128'(srch_hit), 0);
    mic_en = 0;
    srch(48'h0D00_0000_7070, 1'b0);
    chk(srch_hit && srch_idx == 7'd70 && !srch_mic_vld, "R11 TKIP without integrity support",
        {srch_hit, srch_mic_vld}, 2'b10);

    set_ent(50, 48'h0E00_0000_5050, 1'b1, 3'd3, mkkey(50));
    wr(50, 6, 32'h2222_2222);
    @(negedge clk);
    bus_we = 1; bus_addr = BUS_AW'(50 * 8 + 7); bus_wdata = {16'h0, 1'b1, 15'h0600};
    srch_req = 1; srch_addr = 48'h0E00_0000_5050; srch_group = 0;
    @(negedge clk);
    bus_we = 0; srch_req = 0;
    chk(srch_hit && srch_idx == 7'd50 && srch_key == mkkey(50), "R12 same-cycle commit gives old entry",
        {srch_hit, srch_idx}, {1'b1, 7'd50});
    srch(48'h0E00_0000_5050, 1'b0);
    chk(!srch_hit, "R12 old address gone after commit", 128'(srch_hit), 0);
    srch(48'h0C00_4444_4444, 1'b0);
    chk(srch_hit && srch_idx == 7'd50, "R12 new address present", 128'(srch_idx), 128'(50));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule